// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block moves data between a volatile byte array and a shadow nonvolatile array. A store copies every RAM byte into the nonvolatile array. A recall copies every nonvolatile byte back into the RAM. Both transfers run one byte per clock, in ascending address order, over the whole address space.

Three sources can start a store:
- a loss of power while automatic store is enabled;
- a falling edge on the shared busy pin, driven low from outside;
- a software command from the command decoder.

Two sources can start a recall:
- the return of power, including the first power-up after reset;
- a software command.

The busy pin is modelled as a separate input, output and output enable. The block drives it low for the whole of every store. After a pin or software store it drives the pin high for `HI_CYC` cycles and then releases it to the external pull-up. While any transfer runs, `mem_block` stalls RAM traffic. Commands and triggers that arrive while the block is not idle are dropped.

The sequencer has five states:
- `ST_OFF`: power is absent or has not yet been seen.
- `ST_RECALL`: nonvolatile-to-RAM copy.
- `ST_IDLE`: normal access is allowed.
- `ST_STORE`: RAM-to-nonvolatile copy.
- `ST_DRIVE_HI`: the busy pin is driven high.

Its transitions are:
- reset → `ST_OFF`;
- `ST_OFF` → `ST_RECALL` when power is good;
- `ST_RECALL` → `ST_IDLE` on the last address;
- `ST_IDLE` → `ST_STORE` on any store trigger;
- `ST_IDLE` → `ST_OFF` on power loss with automatic store disabled;
- `ST_IDLE` → `ST_RECALL` on a recall command;
- `ST_STORE` → `ST_OFF` on the last address of an automatic store;
- `ST_STORE` → `ST_DRIVE_HI` on the last address of a pin or command store;
- `ST_DRIVE_HI` → `ST_IDLE` after `HI_CYC` cycles.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset with `pwr_good` high, the block recalls all nonvolatile bytes into the RAM before `mem_block` falls, and `recall_done` pulses once.
- R2: A `cmd_op` value of 3'd1 with `cmd_valid` in idle stores every RAM byte to the nonvolatile array. It writes addresses 0 upward, one per cycle, for 2^ADDR_W cycles, and `store_done` is high for exactly the cycle of the last write.
- R3: A `cmd_op` value of 3'd2 with `cmd_valid` in idle recalls every nonvolatile byte into the RAM, and `recall_done` pulses once on the last write.
- R4: In every cycle of any store, `busy_oe` is 1 and `busy_out` is 0.
- R5: After a pin or command store, `busy_oe`=1 with `busy_out`=1 lasts exactly `HI_CYC` cycles, then `busy_oe` returns to 0.
- R6: A falling edge of `busy_in` that the block is not driving, seen in idle, starts a store.
- R7: When `pwr_good` falls in idle with automatic store enabled, a store runs and then releases the pin without any driven-high cycles. `mem_block` stays high until `pwr_good` returns, and a recall follows.
- R8: `cmd_op` 3'd4 disables automatic store and 3'd3 enables it. While it is disabled, power loss writes nothing to the nonvolatile array. Reset leaves it enabled.
- R9: `mem_block` is high in every state but idle. A command received while not idle has no effect: it causes no extra transfer and no extra done pulse.
- R10: When power loss (with automatic store enabled) and a recall command arrive in the same idle cycle, the store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good | input | 1 | High while supply is valid |
| cmd_valid | input | 1 | Command strobe from decoder |
| cmd_op | input | 3 | 1 store, 2 recall, 3 autostore on, 4 autostore off |
| busy_in | input | 1 | Resolved level of the busy pin |
| busy_out | output | 1 | Level driven onto the busy pin |
| busy_oe | output | 1 | Busy pin drive enable |
| mem_block | output | 1 | Stall RAM and command traffic |
| store_done | output | 1 | One-cycle pulse at end of store |
| recall_done | output | 1 | One-cycle pulse at end of recall |
| ram_addr | output | ADDR_W | RAM address during transfer |
| ram_rdata | input | DATA_W | RAM read data (combinational read) |
| ram_we | output | 1 | RAM write enable (recall) |
| ram_wdata | output | DATA_W | RAM write data |
| nv_addr | output | ADDR_W | Nonvolatile array address |
| nv_rdata | input | DATA_W | Nonvolatile read data (combinational read) |
| nv_we | output | 1 | Nonvolatile write enable (store) |
| nv_wdata | output | DATA_W | Nonvolatile write data |

## Verification
The assertions assume that both arrays return read data in the same cycle as the address. They also assume that nothing outside writes the arrays while `mem_block` is high. The bench models both arrays with combinational reads and touches the RAM only while `mem_block` is low. It pulls the busy pin low only while the block is not driving it, and lets go before that store finishes. It changes `pwr_good` only in idle or in `ST_OFF`, never in the middle of a transfer.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RECALL,
        ST_IDLE,
        ST_STORE,
        ST_DRIVE_HI
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_AUTO,
        SRC_PIN,
        SRC_CMD
    } store_src_t;

    localparam logic [2:0] OP_STORE  = 3'd1;
    localparam logic [2:0] OP_RECALL = 3'd2;
    localparam logic [2:0] OP_AS_ON  = 3'd3;
    localparam logic [2:0] OP_AS_OFF = 3'd4;

endpackage

// File: rtl/nv_xfer_trig.sv
module nv_xfer_trig
    import nv_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle,
    input  logic       pwr_good,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       busy_in,
    input  logic       busy_oe,
    output store_src_t req_src,
    output logic       req_recall
);

    logic pin_s1, pin_s2, pin_prev;
    logic as_en_q;
    logic pin_fall;

    // Two-flop synchroniser on the pin, then edge detect; autostore flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_s1   <= 1'b1;
            pin_s2   <= 1'b1;
            pin_prev <= 1'b1;
            as_en_q  <= 1'b1;
        end else begin
            pin_s1   <= busy_in;
            pin_s2   <= pin_s1;
            pin_prev <= pin_s2;
            if (idle && cmd_valid) begin
                if (cmd_op == OP_AS_ON)
                    as_en_q <= 1'b1;
                else if (cmd_op == OP_AS_OFF)
                    as_en_q <= 1'b0;
            end
        end
    end

    assign pin_fall = pin_prev && !pin_s2 && !busy_oe;

    // Fixed priority: power loss, then pin, then command
    always_comb begin
        if (!pwr_good && as_en_q)
            req_src = SRC_AUTO;
        else if (pin_fall)
            req_src = SRC_PIN;
        else if (cmd_valid && cmd_op == OP_STORE)
            req_src = SRC_CMD;
        else
            req_src = SRC_NONE;
        req_recall = cmd_valid && (cmd_op == OP_RECALL);
    end

endmodule

// File: rtl/nv_xfer_cnt.sv
module nv_xfer_cnt #(
    parameter int ADDR_W = 17,
    parameter int HI_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_step,
    input  logic              hi_step,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              hi_last
);

    localparam int HW = $clog2(HI_CYC + 1);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            hi_q <= '0;
        end else begin
            if (addr_step)
                addr <= addr + 1'b1;
            else
                addr <= '0;
            if (hi_step)
                hi_q <= hi_q + 1'b1;
            else
                hi_q <= '0;
        end
    end

    assign addr_last = (addr == ADDR_MAX);
    assign hi_last   = (hi_q == HW'(HI_CYC - 1));

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
    import nv_xfer_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int HI_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              busy_in,
    output logic              busy_out,
    output logic              busy_oe,
    output logic              mem_block,
    output logic              store_done,
    output logic              recall_done,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0] nv_addr,
    input  logic [DATA_W-1:0] nv_rdata,
    output logic              nv_we,
    output logic [DATA_W-1:0] nv_wdata
);

    seq_state_t        state_q, state_d;
    store_src_t        src_q, src_d, req_src;
    logic              req_recall;
    logic              addr_last, hi_last;
    logic [ADDR_W-1:0] xfer_addr;
    logic              in_xfer, in_hi;

    nv_xfer_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (state_q == ST_IDLE),
        .pwr_good   (pwr_good),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .busy_in    (busy_in),
        .busy_oe    (busy_oe),
        .req_src    (req_src),
        .req_recall (req_recall)
    );

    assign in_xfer = (state_q == ST_STORE) || (state_q == ST_RECALL);
    assign in_hi   = (state_q == ST_DRIVE_HI);

    nv_xfer_cnt #(
        .ADDR_W (ADDR_W),
        .HI_CYC (HI_CYC)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_step (in_xfer && !addr_last),
        .hi_step   (in_hi),
        .addr      (xfer_addr),
        .addr_last (addr_last),
        .hi_last   (hi_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            src_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_good)
                    state_d = ST_RECALL;
            end
            ST_RECALL: begin
                if (addr_last)
                    state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_src != SRC_NONE) begin
                    state_d = ST_STORE;
                    src_d   = req_src;
                end else if (!pwr_good) begin
                    state_d = ST_OFF;
                end else if (req_recall) begin
                    state_d = ST_RECALL;
                end
            end
            ST_STORE: begin
                if (addr_last)
                    state_d = (src_q == SRC_AUTO) ? ST_OFF : ST_DRIVE_HI;
            end
            ST_DRIVE_HI: begin
                if (hi_last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        ram_addr    = xfer_addr;
        nv_addr     = xfer_addr;
        ram_wdata   = nv_rdata;
        nv_wdata    = ram_rdata;
        ram_we      = (state_q == ST_RECALL);
        nv_we       = (state_q == ST_STORE);
        busy_oe     = (state_q == ST_STORE) || (state_q == ST_DRIVE_HI);
        busy_out    = (state_q == ST_DRIVE_HI);
        mem_block   = (state_q != ST_IDLE);
        store_done  = (state_q == ST_STORE) && addr_last;
        recall_done = (state_q == ST_RECALL) && addr_last;
    end

endmodule

// File: rtl/nv_xfer_chk.sv
module nv_xfer_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_we,
    input logic              ram_we,
    input logic [ADDR_W-1:0] nv_addr,
    input logic              busy_oe,
    input logic              busy_out,
    input logic              mem_block,
    input logic              store_done,
    input logic              recall_done
);

    p_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> (busy_oe && !busy_out));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we && $past(nv_we)) |-> (nv_addr == ADDR_W'($past(nv_addr) + 1'b1)));

    p_store_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !store_done);

    p_recall_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |=> !recall_done);

    p_block_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we || ram_we) |-> mem_block);

    p_one_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_we && ram_we));

    p_hi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && busy_out) |-> (!nv_we && !ram_we && mem_block));

endmodule

bind nv_xfer_seq nv_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_we       (nv_we),
    .ram_we      (ram_we),
    .nv_addr     (nv_addr),
    .busy_oe     (busy_oe),
    .busy_out    (busy_out),
    .mem_block   (mem_block),
    .store_done  (store_done),
    .recall_done (recall_done)
);

// File: tb/nv_xfer_seq_tb.sv
`timescale 1ns/1ps
module nv_xfer_seq_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int HI    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic          ext_pull = 1'b0;
    logic          busy_in, busy_out, busy_oe, mem_block, store_done, recall_done;
    logic [AW-1:0] ram_addr, nv_addr;
    logic [DW-1:0] ram_rdata, ram_wdata, nv_rdata, nv_wdata;
    logic          ram_we, nv_we;

    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] nv_m  [DEPTH];
    logic [DW-1:0] snap  [DEPTH];

    int  n_chk = 0, n_bad = 0;
    int  st_cyc = 0, hi_cyc = 0;
    int  exp_addr = 0;
    byte exp_q[$];
    bit  finished = 0;

    always #2.5 clk = ~clk;

    assign busy_in   = busy_oe ? busy_out : ~ext_pull;
    assign ram_rdata = ram_m[ram_addr];
    assign nv_rdata  = nv_m[nv_addr];

    always @(posedge clk) begin
        if (ram_we) ram_m[ram_addr] <= ram_wdata;
        if (nv_we)  nv_m[nv_addr]   <= nv_wdata;
    end

    nv_xfer_seq #(.ADDR_W(AW), .DATA_W(DW), .HI_CYC(HI)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected completions, checks store stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (nv_we) begin
                st_cyc++;
                if (!(busy_oe && !busy_out))
                    chk(0, "R4 pin not low in store", busy_out, 0);
                if (nv_addr != exp_addr[AW-1:0])
                    chk(0, "R2 store address order", nv_addr, exp_addr);
                exp_addr++;
            end else begin
                exp_addr = 0;
            end
            if (busy_oe && busy_out) hi_cyc++;
            if (store_done || recall_done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected done pulse", 1, 0);
                end else begin
                    byte k;
                    k = exp_q.pop_front();
                    chk(k == (store_done ? "S" : "R"), "R1/R2/R3 done kind", store_done, k == "S");
                end
            end
        end
    end

    task automatic send(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk);
        while (mem_block && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic fill_ram(input int seed);
        for (int i = 0; i < DEPTH; i++) ram_m[i] = DW'(i * seed + 11);
    endtask

    task automatic take_snap(input bit from_ram);
        for (int i = 0; i < DEPTH; i++) snap[i] = from_ram ? ram_m[i] : nv_m[i];
    endtask

    function automatic int diff_cnt(input bit nv_side);
        int d;
        d = 0;
        for (int i = 0; i < DEPTH; i++)
            if ((nv_side ? nv_m[i] : ram_m[i]) != snap[i]) d++;
        return d;
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            nv_m[i]  = DW'(i * 7 + 3);
            ram_m[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(busy_oe == 0 && store_done == 0 && recall_done == 0 && mem_block == 1,
            "R1 reset outputs", busy_oe, 0);

        // R1: power-up recall
        exp_q.push_back("R");
        take_snap(0);
        rst_n = 1'b1;
        wait_idle();
        chk(diff_cnt(0) == 0, "R1 RAM after power-up recall", diff_cnt(0), 0);
        chk(exp_q.size() == 0, "R1 recall pulse seen", exp_q.size(), 0);

        // R2/R4/R5/R9: command store, recall command during it is dropped
        fill_ram(5);
        take_snap(1);
        st_cyc = 0; hi_cyc = 0;
        exp_q.push_back("S");
        send(3'd1);
        repeat (3) @(negedge clk);
        chk(mem_block == 1, "R9 blocked during store", mem_block, 1);
        send(3'd2);
        wait_idle();
        chk(diff_cnt(1) == 0, "R2 NV after command store", diff_cnt(1), 0);
        chk(st_cyc == DEPTH, "R2 store length", st_cyc, DEPTH);
        chk(hi_cyc == HI, "R5 drive-high length", hi_cyc, HI);
        chk(busy_oe == 0, "R5 pin released", busy_oe, 0);
        chk(exp_q.size() == 0, "R9 no extra transfer", exp_q.size(), 0);
        chk(diff_cnt(0) == 0, "R9 RAM untouched by dropped recall", diff_cnt(0), 0);

        // R3: command recall
        take_snap(0);
        fill_ram(9);
        exp_q.push_back("R");
        send(3'd2);
        wait_idle();
        chk(diff_cnt(0) == 0, "R3 RAM after command recall", diff_cnt(0), 0);

        // R6: pin store
        fill_ram(13);
        take_snap(1);
        st_cyc = 0; hi_cyc = 0;
        exp_q.push_back("S");
        @(negedge clk) ext_pull = 1'b1;
        repeat (3) @(negedge clk);
        ext_pull = 1'b0;
        wait_idle();
        chk(diff_cnt(1) == 0, "R6 NV after pin store", diff_cnt(1), 0);
        chk(hi_cyc == HI, "R5 drive-high after pin store", hi_cyc, HI);

        // R8: autostore disabled, power loss stores nothing
        send(3'd4);
        take_snap(0);
        fill_ram(17);
        st_cyc = 0;
        @(negedge clk) pwr_good = 1'b0;
        repeat (30) @(negedge clk);
        chk(st_cyc == 0 && diff_cnt(1) == 0, "R8 no store while disabled", st_cyc, 0);
        chk(mem_block == 1 && busy_oe == 0, "R7 blocked while off", mem_block, 1);
        exp_q.push_back("R");
        pwr_good = 1'b1;
        wait_idle();
        chk(diff_cnt(0) == 0, "R7 recall on power return", diff_cnt(0), 0);

        // R7: autostore re-enabled
        send(3'd3);
        fill_ram(19);
        take_snap(1);
        st_cyc = 0; hi_cyc = 0;
        exp_q.push_back("S");
        @(negedge clk) pwr_good = 1'b0;
        repeat (DEPTH + 10) @(negedge clk);
        chk(diff_cnt(1) == 0, "R7 NV after autostore", diff_cnt(1), 0);
        chk(hi_cyc == 0 && busy_oe == 0, "R7 no drive-high", hi_cyc, 0);
        chk(mem_block == 1, "R7 still blocked", mem_block, 1);
        exp_q.push_back("R");
        pwr_good = 1'b1;
        wait_idle();

        // R10: power loss and recall command together
        fill_ram(23);
        take_snap(1);
        st_cyc = 0;
        exp_q.push_back("S");
        @(negedge clk);
        pwr_good  = 1'b0;
        cmd_valid = 1'b1;
        cmd_op    = 3'd2;
        @(negedge clk) cmd_valid = 1'b0;
        repeat (DEPTH + 10) @(negedge clk);
        chk(st_cyc == DEPTH && diff_cnt(1) == 0, "R10 store wins", st_cyc, DEPTH);
        exp_q.push_back("R");
        pwr_good = 1'b1;
        wait_idle();

        // R8: reset re-enables autostore
        send(3'd4);
        exp_q.push_back("R");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        wait_idle();
        fill_ram(29);
        take_snap(1);
        st_cyc = 0;
        exp_q.push_back("S");
        @(negedge clk) pwr_good = 1'b0;
        repeat (DEPTH + 10) @(negedge clk);
        chk(st_cyc == DEPTH && diff_cnt(1) == 0, "R8 enabled after reset", st_cyc, DEPTH);
        chk(exp_q.size() == 0, "R1/R8 all completions seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule